// File: doc/BRIEF.md
# Banked Stack Pointer and Thread Privilege Control

This block keeps two 32-bit stack pointers, a main bank and a process bank, next to a two-bit control word. The control word picks which bank thread mode sees and whether thread code runs privileged. Handler mode always sees the main bank and always runs privileged. The core supplies a mode flag. It also supplies one-cycle pulses for exception entry and exception return, a control write port, and a pointer port. The pointer port accepts direct loads plus push and pop strobes. The block presents the visible pointer, the address of the current stack access, the privilege level and the control readback.

Once thread code has dropped privilege, it cannot raise privilege again on its own. Its control writes are discarded. A handler may write the control word, but the new value reaches thread mode only when the exception returns. Until then, the readback shows the value the handler wrote. The stack grows downward and is full-descending, so the visible pointer always names the topmost stored word.

Top module: `stkptr_bank`

## Requirements
- R1: After a synchronous reset, the main bank holds the reset vector word with its two low bits cleared. The process bank holds zero, the control readback is 0, and a thread-mode core is privileged.
- R2: While the handler flag is 1, the visible pointer is the main bank, whatever the select bit says.
- R3: In thread mode, the visible pointer is the main bank when control bit 1 (bank select) is 0 and the process bank when it is 1.
- R4: Control bit 0 set to 1 makes thread mode unprivileged; 0 keeps it privileged. Handler mode is privileged regardless.
- R5: Bits 1:0 of both pointers always read 0. A direct load discards the two low bits of the written value.
- R6: A control write made in unprivileged thread mode has no effect on the control readback, the privilege output or the bank choice.
- R7: A control write in handler mode appears on the readback on the next cycle. It changes thread-mode behaviour only after an exception-return pulse.
- R8: A control write in privileged thread mode takes effect on the cycle after it is presented.
- R9: A push lowers the visible pointer by 4 and presents the lowered value as the access address in the same cycle. A pop raises the pointer by 4 and presents the old pointer as the access address.
- R10: A direct pointer load wins over a push or pop in the same cycle. A push and a pop together leave the pointer unchanged.
- R11: Only the visible bank is changed by loads, pushes and pops. The other bank keeps its value.
- R12: An exception-entry pulse drops a handler control write that has not yet been committed, and the readback returns to the live value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reset_sp_i | input | 32 | Reset vector word used to seed the main bank |
| handler_i | input | 1 | 1 = handler mode, 0 = thread mode |
| exc_entry_i | input | 1 | Exception entry pulse |
| exc_return_i | input | 1 | Exception return pulse |
| ctrl_wr_en_i | input | 1 | Control write strobe |
| ctrl_wr_data_i | input | 2 | Control write value: bit 1 bank select, bit 0 unprivileged |
| sp_wr_en_i | input | 1 | Direct load of the visible pointer |
| sp_wr_data_i | input | 32 | Value for the direct load |
| push_i | input | 1 | Push strobe |
| pop_i | input | 1 | Pop strobe |
| sp_o | output | 32 | Visible stack pointer |
| stack_addr_o | output | 32 | Address of the current push or pop |
| priv_o | output | 1 | 1 = privileged |
| ctrl_rd_o | output | 2 | Control readback |

## Verification
On every cycle, the in-line properties check several rules. Pointer alignment must hold. The hidden bank must stay frozen. A push must step the main bank down by 4, and a load must win over a stack strobe. A discarded unprivileged write must leave the control state untouched. A handler write must stay out of thread behaviour until return, and handler mode must be privileged. Some sequences can only be shown by the bench's scenarios: a handler write that becomes live on return and is then observed back in thread mode, the entry pulse that drops a pending write, and the bank swapping as the mode flag toggles.

// File: rtl/stkptr_pkg.sv
package stkptr_pkg;

    // bit 1: thread bank select, bit 0: thread unprivileged
    typedef struct packed {
        logic use_proc;
        logic unpriv;
    } ctrl_t;

    typedef enum logic {
        BANK_MAIN = 1'b0,
        BANK_PROC = 1'b1
    } bank_e;

    typedef enum logic [1:0] {
        STK_HOLD,
        STK_PUSH,
        STK_POP,
        STK_LOAD
    } stk_op_e;

    localparam int NUM_BANKS = 2;

    function automatic stk_op_e stk_decode(input logic load, input logic push, input logic pop);
        if (load)              return STK_LOAD;
        else if (push && !pop) return STK_PUSH;
        else if (pop && !push) return STK_POP;
        else                   return STK_HOLD;
    endfunction

endpackage

// File: rtl/stkptr_ctrl.sv
module stkptr_ctrl
    import stkptr_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  handler_i,
    input  logic  exc_entry_i,
    input  logic  exc_return_i,
    input  logic  wr_en_i,
    input  ctrl_t wr_data_i,
    output bank_e bank_o,
    output logic  priv_o,
    output ctrl_t rd_o
);
    ctrl_t live_q, pend_q, live_d, pend_d;
    logic  accept;
    logic  thread_priv;

    assign thread_priv = !handler_i && !live_q.unpriv;
    assign accept      = wr_en_i && (handler_i || !live_q.unpriv);

    always_comb begin
        pend_d = pend_q;
        live_d = live_q;
        if (exc_entry_i) pend_d = live_q;
        if (accept)      pend_d = wr_data_i;
        if (thread_priv && wr_en_i) live_d = wr_data_i;
        if (exc_return_i) live_d = pend_d;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            live_q <= '0;
            pend_q <= '0;
        end else begin
            live_q <= live_d;
            pend_q <= pend_d;
        end
    end

    assign bank_o = (!handler_i && live_q.use_proc) ? BANK_PROC : BANK_MAIN;
    assign priv_o = handler_i || !live_q.unpriv;
    assign rd_o   = pend_q;

    // R6
    no_unpriv_wr_chk: assert property (@(posedge clk) disable iff (rst)
        (!handler_i && live_q.unpriv && wr_en_i && !exc_entry_i && !exc_return_i)
        |=> ($stable(live_q) && $stable(pend_q)));

    // R7
    no_early_commit_chk: assert property (@(posedge clk) disable iff (rst)
        (handler_i && !exc_return_i) |=> $stable(live_q));

endmodule

// File: rtl/stkptr_regs.sv
module stkptr_regs
    import stkptr_pkg::*;
#(
    parameter int SP_W       = 32,
    parameter int WORD_BYTES = 4
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [SP_W-1:0] reset_sp_i,
    input  bank_e           bank_i,
    input  logic            wr_en_i,
    input  logic [SP_W-1:0] wr_data_i,
    input  logic            push_i,
    input  logic            pop_i,
    output logic [SP_W-1:0] sp_o,
    output logic [SP_W-1:0] addr_o
);
    localparam int            ALIGN = $clog2(WORD_BYTES);
    localparam logic [SP_W-1:0] STEP = SP_W'(WORD_BYTES);
    localparam logic [SP_W-1:0] MASK = ~((SP_W'(1) << ALIGN) - SP_W'(1));

    stk_op_e         op;
    logic [SP_W-1:0] next_sp;
    logic [SP_W-1:0] bank_val [NUM_BANKS];

    assign op   = stk_decode(wr_en_i, push_i, pop_i);
    assign sp_o = bank_val[bank_i];

    always_comb begin
        unique case (op)
            STK_LOAD: next_sp = wr_data_i & MASK;
            STK_PUSH: next_sp = sp_o - STEP;
            STK_POP:  next_sp = sp_o + STEP;
            default:  next_sp = sp_o;
        endcase
    end

    assign addr_o = (op == STK_PUSH) ? sp_o - STEP : sp_o;

    for (genvar g = 0; g < NUM_BANKS; g++) begin : g_bank
        logic [SP_W-1:0] q;
        logic            sel;
        assign sel = (int'(bank_i) == g);
        always_ff @(posedge clk) begin
            if (rst)
                q <= (g == 0) ? (reset_sp_i & MASK) : '0;
            else if (sel)
                q <= next_sp;
        end
        assign bank_val[g] = q;
    end

    // R5
    sp_align_chk: assert property (@(posedge clk) disable iff (rst)
        sp_o[ALIGN-1:0] == '0);

    // R9
    push_step_chk: assert property (@(posedge clk) disable iff (rst)
        (push_i && !pop_i && !wr_en_i && bank_i == BANK_MAIN)
        |=> (bank_val[0] == $past(bank_val[0]) - STEP));

    // R10
    load_wins_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en_i && bank_i == BANK_PROC)
        |=> (bank_val[1][SP_W-1:ALIGN] == $past(wr_data_i[SP_W-1:ALIGN])));

    // R11
    hidden_bank_chk: assert property (@(posedge clk) disable iff (rst)
        (bank_i == BANK_MAIN) |=> $stable(bank_val[1]));

endmodule

// File: rtl/stkptr_bank.sv
module stkptr_bank
    import stkptr_pkg::*;
#(
    parameter int SP_W       = 32,
    parameter int WORD_BYTES = 4
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [SP_W-1:0] reset_sp_i,
    input  logic            handler_i,
    input  logic            exc_entry_i,
    input  logic            exc_return_i,
    input  logic            ctrl_wr_en_i,
    input  logic [1:0]      ctrl_wr_data_i,
    input  logic            sp_wr_en_i,
    input  logic [SP_W-1:0] sp_wr_data_i,
    input  logic            push_i,
    input  logic            pop_i,
    output logic [SP_W-1:0] sp_o,
    output logic [SP_W-1:0] stack_addr_o,
    output logic            priv_o,
    output logic [1:0]      ctrl_rd_o
);
    bank_e bank;
    ctrl_t rd;

    stkptr_ctrl u_ctrl (
        .clk          (clk),
        .rst          (rst),
        .handler_i    (handler_i),
        .exc_entry_i  (exc_entry_i),
        .exc_return_i (exc_return_i),
        .wr_en_i      (ctrl_wr_en_i),
        .wr_data_i    (ctrl_t'(ctrl_wr_data_i)),
        .bank_o       (bank),
        .priv_o       (priv_o),
        .rd_o         (rd)
    );

    stkptr_regs #(
        .SP_W       (SP_W),
        .WORD_BYTES (WORD_BYTES)
    ) u_regs (
        .clk        (clk),
        .rst        (rst),
        .reset_sp_i (reset_sp_i),
        .bank_i     (bank),
        .wr_en_i    (sp_wr_en_i),
        .wr_data_i  (sp_wr_data_i),
        .push_i     (push_i),
        .pop_i      (pop_i),
        .sp_o       (sp_o),
        .addr_o     (stack_addr_o)
    );

    assign ctrl_rd_o = rd;

    // R4
    handler_priv_chk: assert property (@(posedge clk) disable iff (rst)
        handler_i |-> priv_o);

    // R2
    handler_main_chk: assert property (@(posedge clk) disable iff (rst)
        handler_i |-> (bank == BANK_MAIN));

endmodule

// File: tb/stkptr_bank_bench.sv
module stkptr_bank_bench;
    import stkptr_pkg::*;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] reset_sp = 32'h2000_1003;
    logic        handler = 1'b0, entry = 1'b0, ret = 1'b0;
    logic        cwe = 1'b0;
    logic [1:0]  cwd = 2'b00;
    logic        swe = 1'b0;
    logic [31:0] swd = '0;
    logic        push = 1'b0, pop = 1'b0;
    logic [31:0] sp, addr;
    logic        priv;
    logic [1:0]  crd;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    stkptr_bank u_stkptr_bank (
        .clk(clk), .rst(rst), .reset_sp_i(reset_sp), .handler_i(handler),
        .exc_entry_i(entry), .exc_return_i(ret), .ctrl_wr_en_i(cwe),
        .ctrl_wr_data_i(cwd), .sp_wr_en_i(swe), .sp_wr_data_i(swd),
        .push_i(push), .pop_i(pop), .sp_o(sp), .stack_addr_o(addr),
        .priv_o(priv), .ctrl_rd_o(crd)
    );

    typedef struct packed {
        logic        hnd;
        logic        cwe;
        logic [1:0]  cwd;
        logic        swe;
        logic [31:0] swd;
        logic        push;
        logic        pop;
        logic        ret;
        logic [31:0] esp;
        logic        epriv;
        logic [1:0]  ectrl;
    } vec_t;

    localparam int NV = 18;
    localparam vec_t VEC [NV] = '{
        '{1'b0,1'b0,2'b00,1'b0,32'h0,         1'b1,1'b0,1'b0,32'h2000_0FFC,1'b1,2'b00}, // R9 push
        '{1'b0,1'b0,2'b00,1'b0,32'h0,         1'b1,1'b0,1'b0,32'h2000_0FF8,1'b1,2'b00}, // R9
        '{1'b0,1'b0,2'b00,1'b0,32'h0,         1'b0,1'b1,1'b0,32'h2000_0FFC,1'b1,2'b00}, // R9 pop
        '{1'b0,1'b1,2'b10,1'b0,32'h0,         1'b0,1'b0,1'b0,32'h0000_0000,1'b1,2'b10}, // R8 R3
        '{1'b0,1'b0,2'b00,1'b1,32'h3000_0207, 1'b0,1'b0,1'b0,32'h3000_0204,1'b1,2'b10}, // R5
        '{1'b0,1'b0,2'b00,1'b0,32'h0,         1'b1,1'b0,1'b0,32'h3000_0200,1'b1,2'b10}, // R9
        '{1'b1,1'b0,2'b00,1'b0,32'h0,         1'b0,1'b0,1'b0,32'h2000_0FFC,1'b1,2'b10}, // R2
        '{1'b1,1'b0,2'b00,1'b0,32'h0,         1'b1,1'b0,1'b0,32'h2000_0FF8,1'b1,2'b10}, // R2
        '{1'b0,1'b0,2'b00,1'b0,32'h0,         1'b0,1'b0,1'b0,32'h3000_0200,1'b1,2'b10}, // R11
        '{1'b0,1'b1,2'b11,1'b0,32'h0,         1'b0,1'b0,1'b0,32'h3000_0200,1'b0,2'b11}, // R4
        '{1'b0,1'b1,2'b00,1'b0,32'h0,         1'b0,1'b0,1'b0,32'h3000_0200,1'b0,2'b11}, // R6
        '{1'b0,1'b0,2'b00,1'b1,32'h3000_0100, 1'b1,1'b0,1'b0,32'h3000_0100,1'b0,2'b11}, // R10
        '{1'b0,1'b0,2'b00,1'b0,32'h0,         1'b1,1'b1,1'b0,32'h3000_0100,1'b0,2'b11}, // R10
        '{1'b1,1'b1,2'b00,1'b0,32'h0,         1'b0,1'b0,1'b0,32'h2000_0FF8,1'b1,2'b00}, // R7
        '{1'b1,1'b0,2'b00,1'b0,32'h0,         1'b0,1'b0,1'b1,32'h2000_0FF8,1'b1,2'b00}, // R7 return
        '{1'b0,1'b0,2'b00,1'b0,32'h0,         1'b0,1'b0,1'b0,32'h2000_0FF8,1'b1,2'b00}, // R7 R3
        '{1'b0,1'b0,2'b00,1'b1,32'hFFFF_FFFF, 1'b0,1'b0,1'b0,32'hFFFF_FFFC,1'b1,2'b00}, // R5
        '{1'b0,1'b0,2'b00,1'b0,32'h0,         1'b0,1'b1,1'b0,32'h0000_0000,1'b1,2'b00}  // R9 wrap
    };

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
        cwe = 1'b0; swe = 1'b0; push = 1'b0; pop = 1'b0;
        entry = 1'b0; ret = 1'b0;
    endtask

    initial begin
        #(4 * 200000);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        tick();
        tick();
        rst = 1'b0;
        #1;
        // R1 reset state
        check("R1", "sp",   sp,           32'h2000_1000);
        check("R1", "ctrl", {30'd0, crd}, 32'd0);
        check("R1", "priv", {31'd0, priv}, 32'd1);

        for (int i = 0; i < NV; i++) begin
            handler = VEC[i].hnd;
            cwe  = VEC[i].cwe;  cwd = VEC[i].cwd;
            swe  = VEC[i].swe;  swd = VEC[i].swd;
            push = VEC[i].push; pop = VEC[i].pop;
            ret  = VEC[i].ret;
            tick();
            check($sformatf("row%0d", i), "sp",   sp,            VEC[i].esp);
            check($sformatf("row%0d", i), "priv", {31'd0, priv}, {31'd0, VEC[i].epriv});
            check($sformatf("row%0d", i), "ctrl", {30'd0, crd},  {30'd0, VEC[i].ectrl});
        end

        // R9 access address during push and pop (main bank at 0)
        push = 1'b1;
        #1;
        check("R9", "push addr", addr, 32'hFFFF_FFFC);
        tick();
        check("R9", "sp after push", sp, 32'hFFFF_FFFC);
        pop = 1'b1;
        #1;
        check("R9", "pop addr", addr, 32'hFFFF_FFFC);
        tick();

        // R12 entry drops an uncommitted handler write
        handler = 1'b1;
        cwe = 1'b1; cwd = 2'b11;
        tick();
        check("R12", "pending readback", {30'd0, crd}, 32'd3);
        entry = 1'b1;
        tick();
        check("R12", "after entry", {30'd0, crd}, 32'd0);
        ret = 1'b1;
        tick();
        handler = 1'b0;
        #1;
        check("R12", "thread priv", {31'd0, priv}, 32'd1);
        check("R12", "thread sp", sp, 32'h0000_0000);

        // R2 handler ignores select; R11 process bank kept
        cwe = 1'b1; cwd = 2'b10;
        tick();
        check("R11", "proc bank kept", sp, 32'h3000_0100);
        handler = 1'b1;
        #1;
        check("R2", "handler main", sp, 32'h0000_0000);
        handler = 1'b0;

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule